// File: doc/BRIEF.md
# I2C Master Control and Status Register File

This block is the byte-wide register window that sits in front of an I2C master engine. Software reads and writes it one byte at a time over a simple register bus. The registers hold the transfer control, mode, clock divider, interrupt mask, transfer count, extended control, direct line control and four address bytes. The block feeds the configuration to the transfer sequencer, and the sequencer reports back with completion, abort and halt event pulses and a bus-busy level. The block owns the status bits, the write-one-to-clear rules, the write masks and a registered level interrupt output.

The data buffer at offset 0 is kept by a separate block, so this window returns 0 there. Reads take one cycle: `reg_rdata` is loaded on the clock edge that samples `reg_rd` and holds its value until the next read. A write of 1 to bit 0 of extended control (offset 15) is a soft reset. It returns every register to its reset value except the four address bytes.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After hardware reset, these offsets read as follows: control (6) 0x00, mode (7) 0x00, status (8) 0x00, extended status (9) 0x40 with the bus free, clock divider (12) 0x00, mask (13) 0x00, count (14) 0x00, extended control (15) 0x00, direct control (16) 0x0F. `irq` is 0.
- R2: Mode (7) keeps only the bits under 0x3D, and bit 2 is the global interrupt enable. A write with bit 6 set gives a one-cycle `flush_pulse` on the next cycle, and bit 6 is not stored.
- R3: Transfer count (14) keeps only the bits under 0x77. Clock divider (12), mask (13) and the address bytes (4, 5, 10, 11) keep all eight bits.
- R4: Control (6) stores the written value with bit 0 cleared. A write with bit 0 set gives a one-cycle `go_pulse` and sets status bit 0 (pending). Status bit 0 is cleared by `xfer_done` or `xfer_abort`.
- R5: When `xfer_done` arrives with `xfer_bytes` non-zero while mode bit 2 and mask bit 0 are both set, status bit 1 (interrupt active) and `irq` go to 1 on the next cycle. When `xfer_bytes` is zero, neither changes.
- R6: When `halt_done` arrives while mode bit 2 and mask bit 3 are both set, status bit 1 and `irq` go to 1 on the next cycle.
- R7: When mode bit 2 is clear, or the event's own mask bit is clear, an event changes neither `irq` nor status bit 1.
- R8: A write to status (8) clears the bits set in (value & 0x0A). A 1 in bit 1 also drops `irq`, but only when mode bit 2 is set. Otherwise `irq` stays high.
- R9: When a set event and a clearing status write land in the same cycle, the set event wins for both `irq` and status bit 1.
- R10: Extended status (9) reads as 0x40, plus 0x10 while `bus_busy` is high, plus bit 0 (abort latch). `xfer_abort` sets the abort latch and status bit 2 (error). A write clears the latch bits set in (value & 0x8F). `xfer_done` clears status bit 2.
- R11: A write of bit 0 to extended control (15) applies the R1 values to every register and to `irq` on the next cycle. The address bytes at 4, 5, 10 and 11 keep their values. Writing bits 7:4 of extended control clears them.
- R12: Offsets 0 to 3, 17, and every offset of 18 or above read as 0x00. Read data appears one cycle after `reg_rd` and holds while `reg_rd` is low.
- R13: A write to direct control (16) stores value bits 3:2 and copies bit 2 into bit 0 and bit 3 into bit 1. `scl_level` shows bit 0 and `sda_level` shows bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| xfer_done | input | 1 | Transfer completion event |
| xfer_bytes | input | CNT_W | Bytes moved by the completed transfer |
| xfer_abort | input | 1 | Transfer abort event |
| halt_done | input | 1 | Halt completion event |
| bus_busy | input | 1 | Bus-busy level from the line monitor |
| irq | output | 1 | Level interrupt |
| go_pulse | output | 1 | Start request to the sequencer |
| flush_pulse | output | 1 | Buffer flush request |
| cfg_ctrl | output | DATA_W | Stored control byte |
| cfg_clkdiv | output | DATA_W | Clock divider byte |
| cfg_target | output | DATA_W | Target address byte (offset 4) |
| scl_level | output | 1 | Direct clock line level |
| sda_level | output | 1 | Direct data line level |

## Verification
The hardest case to reach from the ports is a completion event and a status write that clears the interrupt, landing on the same clock edge. The bench raises `reg_wr` and `xfer_done` in the same cycle so that it can observe the priority. A second hard case is an interrupt left high after its active bit was cleared. The bench reaches it by turning off the global enable between raising the interrupt and clearing the status bit, then checks that `irq` stays high until a clear with the enable set. Soft reset is checked after every register holds a non-zero value, so that both the cleared registers and the kept address bytes are visible.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int OFS_TGT_LO  = 4;
  localparam int OFS_TGT_HI  = 5;
  localparam int OFS_CTRL    = 6;
  localparam int OFS_MODE    = 7;
  localparam int OFS_STAT    = 8;
  localparam int OFS_XSTAT   = 9;
  localparam int OFS_OWN_LO  = 10;
  localparam int OFS_OWN_HI  = 11;
  localparam int OFS_CLKDIV  = 12;
  localparam int OFS_MASK    = 13;
  localparam int OFS_COUNT   = 14;
  localparam int OFS_XCTL    = 15;
  localparam int OFS_DIRECT  = 16;

  localparam int NUM_KEEP = 4;
  localparam int KEEP_OFS [NUM_KEEP] = '{OFS_TGT_LO, OFS_TGT_HI, OFS_OWN_LO, OFS_OWN_HI};

  localparam logic [7:0] MODE_KEEP   = 8'h3D;
  localparam logic [7:0] COUNT_KEEP  = 8'h77;
  localparam logic [7:0] STAT_W1C    = 8'h0A;
  localparam logic [7:0] XSTAT_W1C   = 8'h8F;
  localparam logic [7:0] XCTL_W1C    = 8'hF0;
  localparam logic [7:0] DIRECT_INIT = 8'h0F;

  localparam int MODE_IEN_BIT   = 2;
  localparam int MODE_FLUSH_BIT = 6;
  localparam int MASK_DONE_BIT  = 0;
  localparam int MASK_HALT_BIT  = 3;
endpackage

// File: rtl/i2cr_event_unit.sv
module i2cr_event_unit #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             go,
  input  logic             sts_wr,
  input  logic             sts_clr_act,
  input  logic             xs_wr,
  input  logic             xs_clr_abort,
  input  logic             ien,
  input  logic             mask_done,
  input  logic             mask_halt,
  input  logic             xfer_done,
  input  logic [CNT_W-1:0] xfer_bytes,
  input  logic             xfer_abort,
  input  logic             halt_done,
  output logic             irq,
  output logic             pend,
  output logic             act,
  output logic             err,
  output logic             abort_flag
);
  logic set_evt;
  logic clr_act;

  assign set_evt = ien && ((xfer_done && (xfer_bytes != '0) && mask_done) ||
                           (halt_done && mask_halt));
  assign clr_act = sts_wr && sts_clr_act;

  always_ff @(posedge clk) begin
    if (clr) begin
      irq        <= 1'b0;
      act        <= 1'b0;
      pend       <= 1'b0;
      err        <= 1'b0;
      abort_flag <= 1'b0;
    end else begin
      if (set_evt)             act <= 1'b1;
      else if (clr_act)        act <= 1'b0;

      if (set_evt)             irq <= 1'b1;
      else if (clr_act && ien) irq <= 1'b0;

      if (go)                             pend <= 1'b1;
      else if (xfer_done || xfer_abort)   pend <= 1'b0;

      if (xfer_abort)      err <= 1'b1;
      else if (xfer_done)  err <= 1'b0;

      if (xfer_abort)                    abort_flag <= 1'b1;
      else if (xs_wr && xs_clr_abort)    abort_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cr_read_port.sv
module i2cr_read_port
  import i2cr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int WINDOW = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] keep_val [NUM_KEEP],
  input  logic [DATA_W-1:0] ctrl,
  input  logic [DATA_W-1:0] mode,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] xstatus,
  input  logic [DATA_W-1:0] clkdiv,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] xctl,
  input  logic [DATA_W-1:0] direct,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;
  int                a;

  always_comb begin
    a   = int'(addr);
    sel = '0;
    if (a < WINDOW) begin
      case (a)
        OFS_TGT_LO: sel = keep_val[0];
        OFS_TGT_HI: sel = keep_val[1];
        OFS_OWN_LO: sel = keep_val[2];
        OFS_OWN_HI: sel = keep_val[3];
        OFS_CTRL:   sel = ctrl;
        OFS_MODE:   sel = mode;
        OFS_STAT:   sel = status;
        OFS_XSTAT:  sel = xstatus;
        OFS_CLKDIV: sel = clkdiv;
        OFS_MASK:   sel = mask;
        OFS_COUNT:  sel = count;
        OFS_XCTL:   sel = xctl;
        OFS_DIRECT: sel = direct;
        default:    sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel;
  end
endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2cr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 3,
  parameter int WINDOW = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              xfer_done,
  input  logic [CNT_W-1:0]  xfer_bytes,
  input  logic              xfer_abort,
  input  logic              halt_done,
  input  logic              bus_busy,
  output logic              irq,
  output logic              go_pulse,
  output logic              flush_pulse,
  output logic [DATA_W-1:0] cfg_ctrl,
  output logic [DATA_W-1:0] cfg_clkdiv,
  output logic [DATA_W-1:0] cfg_target,
  output logic              scl_level,
  output logic              sda_level
);
  localparam logic [DATA_W-1:0] MODE_M   = DATA_W'(MODE_KEEP);
  localparam logic [DATA_W-1:0] COUNT_M  = DATA_W'(COUNT_KEEP);
  localparam logic [DATA_W-1:0] XCTL_M   = DATA_W'(XCTL_W1C);
  localparam logic [DATA_W-1:0] DIR_INIT = DATA_W'(DIRECT_INIT);

  logic [DATA_W-1:0] ctrl_q, mode_q, clkdiv_q, mask_q, count_q, xctl_q, direct_q;
  logic [DATA_W-1:0] keep_q [NUM_KEEP];
  logic [DATA_W-1:0] status_v, xstatus_v;
  logic              soft_rst, clr, go_req;
  logic              pend, act, err, abort_flag;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return int'(a) == ofs;
  endfunction

  assign soft_rst = reg_wr && hit(reg_addr, OFS_XCTL) && reg_wdata[0];
  assign clr      = rst || soft_rst;
  assign go_req   = reg_wr && hit(reg_addr, OFS_CTRL) && reg_wdata[0];

  // configuration registers cleared by either reset
  always_ff @(posedge clk) begin
    if (clr) begin
      ctrl_q   <= '0;
      mode_q   <= '0;
      clkdiv_q <= '0;
      mask_q   <= '0;
      count_q  <= '0;
      xctl_q   <= '0;
      direct_q <= DIR_INIT;
    end else if (reg_wr) begin
      case (int'(reg_addr))
        OFS_CTRL:   ctrl_q   <= {reg_wdata[DATA_W-1:1], 1'b0};
        OFS_MODE:   mode_q   <= reg_wdata & MODE_M;
        OFS_CLKDIV: clkdiv_q <= reg_wdata;
        OFS_MASK:   mask_q   <= reg_wdata;
        OFS_COUNT:  count_q  <= reg_wdata & COUNT_M;
        OFS_XCTL:   xctl_q   <= xctl_q & ~(reg_wdata & XCTL_M);
        OFS_DIRECT: direct_q <= {{(DATA_W-4){1'b0}}, reg_wdata[3], reg_wdata[2],
                                 reg_wdata[3], reg_wdata[2]};
        default: ;
      endcase
    end
  end

  // request pulses toward the sequencer
  always_ff @(posedge clk) begin
    if (clr) begin
      go_pulse    <= 1'b0;
      flush_pulse <= 1'b0;
    end else begin
      go_pulse    <= go_req;
      flush_pulse <= reg_wr && hit(reg_addr, OFS_MODE) && reg_wdata[MODE_FLUSH_BIT];
    end
  end

  // address bytes: hardware reset only, untouched by soft reset
  for (genvar g = 0; g < NUM_KEEP; g++) begin : g_keep
    always_ff @(posedge clk) begin
      if (rst)                                 keep_q[g] <= '0;
      else if (reg_wr && hit(reg_addr, KEEP_OFS[g])) keep_q[g] <= reg_wdata;
    end
  end

  i2cr_event_unit #(.CNT_W(CNT_W)) u_evt (
    .clk          (clk),
    .clr          (clr),
    .go           (go_req),
    .sts_wr       (reg_wr && hit(reg_addr, OFS_STAT)),
    .sts_clr_act  (reg_wdata[1] & STAT_W1C[1]),
    .xs_wr        (reg_wr && hit(reg_addr, OFS_XSTAT)),
    .xs_clr_abort (reg_wdata[0] & XSTAT_W1C[0]),
    .ien          (mode_q[MODE_IEN_BIT]),
    .mask_done    (mask_q[MASK_DONE_BIT]),
    .mask_halt    (mask_q[MASK_HALT_BIT]),
    .xfer_done    (xfer_done),
    .xfer_bytes   (xfer_bytes),
    .xfer_abort   (xfer_abort),
    .halt_done    (halt_done),
    .irq          (irq),
    .pend         (pend),
    .act          (act),
    .err          (err),
    .abort_flag   (abort_flag)
  );

  assign status_v  = {{(DATA_W-3){1'b0}}, err, act, pend};
  assign xstatus_v = {{(DATA_W-7){1'b0}}, 1'b1, 1'b0, bus_busy, 3'b000, abort_flag};

  i2cr_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WINDOW(WINDOW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd       (reg_rd),
    .addr     (reg_addr),
    .keep_val (keep_q),
    .ctrl     (ctrl_q),
    .mode     (mode_q),
    .status   (status_v),
    .xstatus  (xstatus_v),
    .clkdiv   (clkdiv_q),
    .mask     (mask_q),
    .count    (count_q),
    .xctl     (xctl_q),
    .direct   (direct_q),
    .rdata    (reg_rdata)
  );

  assign cfg_ctrl   = ctrl_q;
  assign cfg_clkdiv = clkdiv_q;
  assign cfg_target = keep_q[0];
  assign scl_level  = direct_q[0];
  assign sda_level  = direct_q[1];
endmodule

// File: rtl/i2c_ctl_regs_chk.sv
module i2c_ctl_regs_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              xfer_done,
  input logic [CNT_W-1:0]  xfer_bytes,
  input logic              halt_done,
  input logic              irq,
  input logic              go_pulse,
  input logic              flush_pulse,
  input logic [DATA_W-1:0] mode_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              soft_rst
);
  logic ev_done, ev_halt, clr_wr;
  assign ev_done = xfer_done && (xfer_bytes != '0) && mode_q[2] && mask_q[0];
  assign ev_halt = halt_done && mode_q[2] && mask_q[3];
  assign clr_wr  = reg_wr && (int'(reg_addr) == 8) && reg_wdata[1];

  assert_done_irq_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_done && !soft_rst) |=> irq);

  assert_halt_irq_R6: assert property (@(posedge clk) disable iff (rst)
    (ev_halt && !soft_rst) |=> irq);

  assert_rise_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(mode_q[2]));

  assert_clear_lowers_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && mode_q[2] && !ev_done && !ev_halt) |=> !irq);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && (ev_done || ev_halt) && !soft_rst) |=> irq);

  assert_flush_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && int'(reg_addr) == 7 && reg_wdata[6]) |=> flush_pulse);

  assert_go_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && int'(reg_addr) == 6 && reg_wdata[0]) |=> go_pulse);

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!irq && mode_q == '0 && mask_q == '0));
endmodule

bind i2c_ctl_regs i2c_ctl_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .xfer_done   (xfer_done),
  .xfer_bytes  (xfer_bytes),
  .halt_done   (halt_done),
  .irq         (irq),
  .go_pulse    (go_pulse),
  .flush_pulse (flush_pulse),
  .mode_q      (mode_q),
  .mask_q      (mask_q),
  .soft_rst    (soft_rst)
);

// File: tb/i2c_ctl_regs_bench.sv
`timescale 1ns/1ps
module i2c_ctl_regs_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       xfer_done = 1'b0, xfer_abort = 1'b0, halt_done = 1'b0, bus_busy = 1'b0;
  logic [2:0] xfer_bytes = '0;
  logic       irq, go_pulse, flush_pulse, scl_level, sda_level;
  logic [7:0] cfg_ctrl, cfg_clkdiv, cfg_target;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  i2c_ctl_regs u_i2c_ctl_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .xfer_bytes(xfer_bytes), .xfer_abort(xfer_abort), .halt_done(halt_done),
    .bus_busy(bus_busy), .irq(irq), .go_pulse(go_pulse), .flush_pulse(flush_pulse),
    .cfg_ctrl(cfg_ctrl), .cfg_clkdiv(cfg_clkdiv), .cfg_target(cfg_target),
    .scl_level(scl_level), .sda_level(sda_level)
  );

  // {offset, write value, expected read-back}
  localparam int NV = 14;
  localparam logic [23:0] VEC [NV] = '{
    {8'd7,  8'hFF, 8'h3D},   // R2 mode mask
    {8'd7,  8'h42, 8'h00},   // R2
    {8'd14, 8'hFF, 8'h77},   // R3 count mask
    {8'd14, 8'h88, 8'h00},   // R3
    {8'd12, 8'hA5, 8'hA5},   // R3 clkdiv
    {8'd13, 8'h5A, 8'h5A},   // R3 mask
    {8'd4,  8'h3C, 8'h3C},   // R3 address bytes
    {8'd5,  8'h81, 8'h81},
    {8'd10, 8'h11, 8'h11},
    {8'd11, 8'h22, 8'h22},
    {8'd6,  8'hF6, 8'hF6},   // R4 control, bit 0 clear
    {8'd16, 8'h04, 8'h05},   // R13 direct control
    {8'd16, 8'h08, 8'h0A},   // R13
    {8'd15, 8'hF0, 8'h00}    // R11 extended control clear bits
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a[4:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a[4:0];
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic ev(input logic dn, input logic [2:0] nb, input logic ab, input logic hl);
    xfer_done = dn; xfer_bytes = nb; xfer_abort = ab; halt_done = hl;
    @(negedge clk);
    xfer_done = 1'b0; xfer_bytes = '0; xfer_abort = 1'b0; halt_done = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    rdchk("R1 ctrl", 6, 8'h00);   rdchk("R1 mode", 7, 8'h00);
    rdchk("R1 stat", 8, 8'h00);   rdchk("R1 xstat", 9, 8'h40);
    rdchk("R1 clkdiv", 12, 8'h00); rdchk("R1 mask", 13, 8'h00);
    rdchk("R1 count", 14, 8'h00); rdchk("R1 xctl", 15, 8'h00);
    rdchk("R1 direct", 16, 8'h0F);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rdchk($sformatf("vector %0d (R2 R3 R4 R11 R13)", i), VEC[i][23:16], VEC[i][7:0]);
    end
    check("R13 scl", {7'b0, scl_level}, 8'h00);
    check("R13 sda", {7'b0, sda_level}, 8'h01);
    check("R3 target out", cfg_target, 8'h3C);

    // R12 unmapped offsets and hold
    rdchk("R12 ofs0", 0, 8'h00);  rdchk("R12 ofs3", 3, 8'h00);
    rdchk("R12 ofs17", 17, 8'h00); rdchk("R12 ofs20", 20, 8'h00);
    rdchk("R12 ofs31", 31, 8'h00);
    rdchk("R12 load", 12, 8'hA5);
    @(negedge clk);
    check("R12 hold", reg_rdata, 8'hA5);

    // R2 flush pulse
    wr(7, 8'h40);
    check("R2 flush on", {7'b0, flush_pulse}, 8'h01);
    @(negedge clk);
    check("R2 flush off", {7'b0, flush_pulse}, 8'h00);
    rdchk("R2 flush not stored", 7, 8'h00);

    // R4 go and pending
    wr(13, 8'h00);
    wr(6, 8'h03);
    check("R4 go", {7'b0, go_pulse}, 8'h01);
    rdchk("R4 pending", 8, 8'h01);
    rdchk("R4 ctrl", 6, 8'h02);
    ev(1, 0, 0, 0);
    rdchk("R4 pending cleared", 8, 8'h00);

    // R5 completion interrupt
    wr(7, 8'h04); wr(13, 8'h01);
    ev(1, 0, 0, 0);
    check("R5 zero bytes irq", {7'b0, irq}, 8'h00);
    ev(1, 2, 0, 0);
    check("R5 irq", {7'b0, irq}, 8'h01);
    rdchk("R5 act", 8, 8'h02);

    // R8 clear with enable
    wr(8, 8'h0A);
    check("R8 irq low", {7'b0, irq}, 8'h00);
    rdchk("R8 act clear", 8, 8'h00);

    // R6 halt interrupt
    wr(13, 8'h08);
    ev(1, 1, 0, 0);
    check("R6 done masked", {7'b0, irq}, 8'h00);
    ev(0, 0, 0, 1);
    check("R6 irq", {7'b0, irq}, 8'h01);
    wr(8, 8'h02);
    check("R6 clear", {7'b0, irq}, 8'h00);

    // R7 missing enable / missing mask
    wr(13, 8'h09); wr(7, 8'h00);
    ev(1, 3, 0, 1);
    check("R7 no enable irq", {7'b0, irq}, 8'h00);
    rdchk("R7 no enable act", 8, 8'h00);
    wr(7, 8'h04); wr(13, 8'h00);
    ev(1, 3, 0, 1);
    check("R7 no mask irq", {7'b0, irq}, 8'h00);
    rdchk("R7 no mask act", 8, 8'h00);

    // R8 clear without enable leaves irq high
    wr(13, 8'h01);
    ev(1, 1, 0, 0);
    wr(7, 8'h00);
    wr(8, 8'h02);
    check("R8 irq stays", {7'b0, irq}, 8'h01);
    rdchk("R8 act cleared", 8, 8'h00);
    wr(7, 8'h04);
    wr(8, 8'h02);
    check("R8 irq lowered", {7'b0, irq}, 8'h00);

    // R9 set beats clear in the same cycle
    reg_wr = 1'b1; reg_addr = 5'd8; reg_wdata = 8'h02;
    xfer_done = 1'b1; xfer_bytes = 3'd1;
    @(negedge clk);
    reg_wr = 1'b0; xfer_done = 1'b0; xfer_bytes = '0;
    check("R9 irq", {7'b0, irq}, 8'h01);
    rdchk("R9 act", 8, 8'h02);
    wr(8, 8'h02);

    // R10 extended status and abort
    rdchk("R10 free", 9, 8'h40);
    bus_busy = 1'b1;
    rdchk("R10 busy", 9, 8'h50);
    bus_busy = 1'b0;
    ev(0, 0, 1, 0);
    rdchk("R10 abort latch", 9, 8'h41);
    rdchk("R10 error bit", 8, 8'h04);
    wr(9, 8'h0E);
    rdchk("R10 other bits no effect", 9, 8'h41);
    wr(9, 8'h01);
    rdchk("R10 latch cleared", 9, 8'h40);
    ev(1, 0, 0, 0);
    rdchk("R10 error cleared", 8, 8'h00);

    // R11 soft reset
    wr(12, 8'h33); wr(14, 8'h21); wr(16, 8'h00); wr(6, 8'h80);
    wr(13, 8'h01); wr(7, 8'h04);
    ev(1, 1, 0, 0);
    check("R11 pre irq", {7'b0, irq}, 8'h01);
    wr(15, 8'h01);
    check("R11 irq", {7'b0, irq}, 8'h00);
    rdchk("R11 ctrl", 6, 8'h00);  rdchk("R11 mode", 7, 8'h00);
    rdchk("R11 stat", 8, 8'h00);  rdchk("R11 clkdiv", 12, 8'h00);
    rdchk("R11 mask", 13, 8'h00); rdchk("R11 count", 14, 8'h00);
    rdchk("R11 direct", 16, 8'h0F);
    rdchk("R11 keep 4", 4, 8'h3C);  rdchk("R11 keep 5", 5, 8'h81);
    rdchk("R11 keep 10", 10, 8'h11); rdchk("R11 keep 11", 11, 8'h22);
    check("R13 scl after reset", {7'b0, scl_level}, 8'h01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule